// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a dual-slope integrating converter. It drives the analog switches through a fixed sequence of phases. Auto-zero nulls the front end. Signal integrate charges the integrator from the input for a fixed number of clocks. Reference deintegrate discharges it with a reference of the opposite sign, and a binary counter measures how long that takes. A recovery phase follows only when the measurement ran off the end of its range. In that phase the integrator is actively driven back to zero, so that no residue leaks into the next measurement.

Every conversion takes the same number of clocks, because auto-zero absorbs whatever time the other phases leave over. The result is a count, a polarity bit and an overrange bit. It is written into output registers at the moment the comparator reports that the integrator has returned through zero. A busy/valid flag goes high when signal integration begins. It drops half a clock after the result registers are written, and the result never changes while the flag is low. A run/hold input lets the host let conversions follow each other continuously or park the sequencer in auto-zero between conversions.

All lengths derive from one width parameter `CNT_W`, which is 12 by default. That default gives a 2048-clock integrate, a deintegrate of up to 4096 clocks, a recovery phase of up to 1024 clocks and an 8192-clock conversion.

Top module: `adc_seq_top`

## Requirements
- R1: While `rstN` is low, `status` is 0, `selAutoZero` and `selRefCharge` are 1, every other select output is 0, and `resCount`, `resPolarity` and `resOverrange` are 0.
- R2: Signal integrate (`selSignal` high) lasts exactly 2^(CNT_W-1) clocks. The comparator level sampled on its last clock becomes the polarity, with 1 meaning the comparator was high.
- R3: During deintegrate, `selRefForPos` is high when the polarity is 1 and `selRefForNeg` is high when it is 0. The result count is the number of deintegrate clocks that came before the first clock on which the comparator differs from the polarity, so a flip on the very first clock gives 0.
- R4: If the comparator has not differed from the polarity after 2^CNT_W deintegrate clocks, the result is written with the count all ones and `resOverrange` at 1. A flip on the last allowed clock is still an in-range result.
- R5: The recovery phase (`selZeroFb` high) follows only a deintegrate that ended in overrange. During recovery `selRefCharge` is high and `selSignal` is low. An in-range result is followed directly by auto-zero.
- R6: Recovery ends on the first clock on which the comparator differs from the polarity, or after 2^(CNT_W-2) clocks, whichever comes first.
- R7: `status` rises on the same clock edge on which signal integrate begins.
- R8: `status` falls on the falling clock edge that follows the rising edge that writes the result. The result outputs change only while `status` is high.
- R9: While `runHold` stays high, a new signal integrate begins every 2^(CNT_W+1) clocks, with no idle clocks between conversions.
- R10: With `runHold` low, the conversion in progress completes and the sequencer then stays in auto-zero with `status` low. After `runHold` rises, signal integrate starts at the next rising edge.
- R11: At all times exactly one of auto-zero, signal integrate, deintegrate (either reference select) or recovery is selected. `selRefCharge` is never high together with `selSignal` or a reference select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runHold | input | 1 | 1: conversions follow each other; 0: park in auto-zero after the current one |
| compOut | input | 1 | Comparator output, high when the integrator sits above zero |
| selAutoZero | output | 1 | Auto-zero switch group closed |
| selSignal | output | 1 | Input signal connected to the integrator |
| selRefForPos | output | 1 | Reference applied that discharges a positive integration |
| selRefForNeg | output | 1 | Reference applied that discharges a negative integration |
| selRefCharge | output | 1 | Reference capacitor charging switch closed |
| selZeroFb | output | 1 | Comparator-to-buffer feedback path enabled (recovery) |
| resCount | output | CNT_W | Latched conversion count |
| resPolarity | output | 1 | Latched polarity, 1 = positive |
| resOverrange | output | 1 | Latched overrange flag |
| status | output | 1 | Conversion busy; its falling edge marks new valid data |

## Verification
A corrupted phase register or phase counter shows up within one conversion period. It appears as a wrong number of integrate or deintegrate clocks at the select outputs, a recovery phase that appears without an overrange or overstays its limit, or a result count off by the error. A corrupted cycle counter shifts the next rise of `status` away from its fixed spacing, so it is caught at the following conversion start. A stuck or mistimed busy register is seen immediately: the flag is high without an integrate, it is low while the result changes, or it falls at a time other than half a clock after the write.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    PH_AUTOZERO = 2'd0,
    PH_INTEG    = 2'd1,
    PH_DEINT    = 2'd2,
    PH_ZEROINT  = 2'd3
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cycRestart;
    logic cycHold;
    logic phClear;
    logic phInc;
    logic polCapture;
    logic latchCross;
    logic latchOver;
    logic busySet;
  } seqStrobe_t;

  // conditions reported back by the datapath
  typedef struct packed {
    logic cycEnd;
    logic integEnd;
    logic deintLimit;
    logic zeroIntLimit;
    logic crossing;
    logic polarity;
  } seqFlag_t;

endpackage

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             compOut,
  input  seqStrobe_t       strobe,
  output seqFlag_t         flag,
  output logic [CNT_W-1:0] resCount,
  output logic             resPolarity,
  output logic             resOverrange,
  output logic             status
);

  localparam int CYC_W      = CNT_W + 1;
  localparam int INTEG_LEN  = 2 ** (CNT_W - 1);
  localparam int CYCLE_LEN  = 2 ** (CNT_W + 1);
  localparam int ZI_MAX     = 2 ** (CNT_W - 2);
  localparam logic [CYC_W-1:0] CYC_LAST   = CYC_W'(CYCLE_LEN - 1);
  localparam logic [CYC_W-1:0] INTEG_LAST = CYC_W'(INTEG_LEN - 1);
  localparam logic [CNT_W-1:0] ZI_LAST    = CNT_W'(ZI_MAX - 1);

  logic [CYC_W-1:0] cycCnt;
  logic [CNT_W-1:0] phCnt;
  logic             polQ;
  logic             busyQ;
  logic             busyNeg;

  // conversion-wide timer; rests on its last value while parked
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 cycCnt <= CYC_LAST;
    else if (strobe.cycRestart) cycCnt <= '0;
    else if (!strobe.cycHold)   cycCnt <= cycCnt + 1'b1;
  end

  // shared counter for deintegrate and recovery
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              phCnt <= '0;
    else if (strobe.phClear) phCnt <= '0;
    else if (strobe.phInc)   phCnt <= phCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 polQ <= 1'b0;
    else if (strobe.polCapture) polQ <= compOut;
  end

  // result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resCount     <= '0;
      resPolarity  <= 1'b0;
      resOverrange <= 1'b0;
    end else if (strobe.latchCross) begin
      resCount     <= phCnt;
      resPolarity  <= polQ;
      resOverrange <= 1'b0;
    end else if (strobe.latchOver) begin
      resCount     <= '1;
      resPolarity  <= polQ;
      resOverrange <= 1'b1;
    end
  end

  // busy: set with integrate, cleared with the write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                     busyQ <= 1'b0;
    else if (strobe.busySet)                       busyQ <= 1'b1;
    else if (strobe.latchCross || strobe.latchOver) busyQ <= 1'b0;
  end

  // falling-edge copy stretches the flag by half a clock
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) busyNeg <= 1'b0;
    else       busyNeg <= busyQ;
  end

  assign status = busyQ | busyNeg;

  assign flag.cycEnd       = (cycCnt == CYC_LAST);
  assign flag.integEnd     = (cycCnt == INTEG_LAST);
  assign flag.deintLimit   = &phCnt;
  assign flag.zeroIntLimit = (phCnt == ZI_LAST);
  assign flag.crossing     = (compOut != polQ);
  assign flag.polarity     = polQ;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       runHold,
  input  seqFlag_t   flag,
  output seqStrobe_t strobe,
  output logic       selAutoZero,
  output logic       selSignal,
  output logic       selRefForPos,
  output logic       selRefForNeg,
  output logic       selRefCharge,
  output logic       selZeroFb
);

  phase_e phase;
  phase_e nextPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_AUTOZERO;
    else       phase <= nextPhase;
  end

  always_comb begin
    nextPhase = phase;
    strobe    = '0;
    case (phase)
      PH_AUTOZERO: begin
        if (flag.cycEnd) begin
          if (runHold) begin
            nextPhase         = PH_INTEG;
            strobe.cycRestart = 1'b1;
            strobe.busySet    = 1'b1;
          end else begin
            strobe.cycHold = 1'b1;
          end
        end
      end
      PH_INTEG: begin
        if (flag.integEnd) begin
          nextPhase         = PH_DEINT;
          strobe.polCapture = 1'b1;
          strobe.phClear    = 1'b1;
        end
      end
      PH_DEINT: begin
        if (flag.crossing) begin
          nextPhase         = PH_AUTOZERO;
          strobe.latchCross = 1'b1;
        end else if (flag.deintLimit) begin
          nextPhase        = PH_ZEROINT;
          strobe.latchOver = 1'b1;
          strobe.phClear   = 1'b1;
        end else begin
          strobe.phInc = 1'b1;
        end
      end
      PH_ZEROINT: begin
        if (flag.crossing || flag.zeroIntLimit) nextPhase = PH_AUTOZERO;
        else                                    strobe.phInc = 1'b1;
      end
      default: nextPhase = PH_AUTOZERO;
    endcase
  end

  assign selAutoZero  = (phase == PH_AUTOZERO);
  assign selSignal    = (phase == PH_INTEG);
  assign selRefForPos = (phase == PH_DEINT) &&  flag.polarity;
  assign selRefForNeg = (phase == PH_DEINT) && !flag.polarity;
  assign selZeroFb    = (phase == PH_ZEROINT);
  assign selRefCharge = (phase == PH_AUTOZERO) || (phase == PH_ZEROINT);

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runHold,
  input  logic             compOut,
  output logic             selAutoZero,
  output logic             selSignal,
  output logic             selRefForPos,
  output logic             selRefForNeg,
  output logic             selRefCharge,
  output logic             selZeroFb,
  output logic [CNT_W-1:0] resCount,
  output logic             resPolarity,
  output logic             resOverrange,
  output logic             status
);

  seqStrobe_t strobe;
  seqFlag_t   flag;

  adc_seq_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .runHold      (runHold),
    .flag         (flag),
    .strobe       (strobe),
    .selAutoZero  (selAutoZero),
    .selSignal    (selSignal),
    .selRefForPos (selRefForPos),
    .selRefForNeg (selRefForNeg),
    .selRefCharge (selRefCharge),
    .selZeroFb    (selZeroFb)
  );

  adc_seq_dp #(.CNT_W(CNT_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .compOut      (compOut),
    .strobe       (strobe),
    .flag         (flag),
    .resCount     (resCount),
    .resPolarity  (resPolarity),
    .resOverrange (resOverrange),
    .status       (status)
  );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             selAutoZero,
  input logic             selSignal,
  input logic             selRefForPos,
  input logic             selRefForNeg,
  input logic             selRefCharge,
  input logic             selZeroFb,
  input logic [CNT_W-1:0] resCount,
  input logic             resPolarity,
  input logic             resOverrange,
  input logic             status
);

  localparam int RUN_W     = CNT_W + 3;
  localparam int INTEG_LEN = 2 ** (CNT_W - 1);
  localparam int DEINT_MAX = 2 ** CNT_W;
  localparam int ZI_MAX    = 2 ** (CNT_W - 2);
  localparam int CYCLE_LEN = 2 ** (CNT_W + 1);

  logic [RUN_W-1:0] intRun, deRun, ziRun, gapRun;
  logic             sigPrev, seenRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intRun   <= '0;
      deRun    <= '0;
      ziRun    <= '0;
      gapRun   <= '0;
      sigPrev  <= 1'b0;
      seenRise <= 1'b0;
    end else begin
      intRun  <= selSignal ? intRun + 1'b1 : '0;
      deRun   <= (selRefForPos || selRefForNeg) ? deRun + 1'b1 : '0;
      ziRun   <= selZeroFb ? ziRun + 1'b1 : '0;
      sigPrev <= selSignal;
      if (selSignal && !sigPrev) begin
        gapRun   <= RUN_W'(1);
        seenRise <= 1'b1;
      end else if (gapRun != '1) begin
        gapRun <= gapRun + 1'b1;
      end
    end
  end

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({selAutoZero, selSignal, selRefForPos || selRefForNeg, selZeroFb})); // R11

  AST_CHARGE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    selRefCharge |-> !(selSignal || selRefForPos || selRefForNeg)); // R11

  AST_INT_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(selSignal) |-> (intRun == RUN_W'(INTEG_LEN))); // R2

  AST_DEINT_CAP: assert property (@(posedge clk) disable iff (!rstN)
    deRun <= RUN_W'(DEINT_MAX)); // R4

  AST_ZI_AFTER_OVR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selZeroFb) |-> resOverrange); // R5

  AST_ZI_CAP: assert property (@(posedge clk) disable iff (!rstN)
    ziRun <= RUN_W'(ZI_MAX)); // R6

  AST_STATUS_AT_INT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selSignal) |-> status); // R7

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!status && !$past(status)) |-> $stable({resCount, resPolarity, resOverrange})); // R8

  AST_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    (selSignal && !sigPrev && seenRise) |-> (gapRun >= RUN_W'(CYCLE_LEN))); // R9

endmodule

bind adc_seq_top adc_seq_chk #(.CNT_W(CNT_W)) u_adc_seq_chk (
  .clk          (clk),
  .rstN         (rstN),
  .selAutoZero  (selAutoZero),
  .selSignal    (selSignal),
  .selRefForPos (selRefForPos),
  .selRefForNeg (selRefForNeg),
  .selRefCharge (selRefCharge),
  .selZeroFb    (selZeroFb),
  .resCount     (resCount),
  .resPolarity  (resPolarity),
  .resOverrange (resOverrange),
  .status       (status)
);

// File: tb/test_adc_seq_top.sv
`timescale 1ns/1ps
module test_adc_seq_top;

  localparam int    CNT_W     = 6;
  localparam int    INTEG_LEN = 2 ** (CNT_W - 1);
  localparam int    DEINT_MAX = 2 ** CNT_W;
  localparam int    ZI_MAX    = 2 ** (CNT_W - 2);
  localparam int    CYCLE_LEN = 2 ** (CNT_W + 1);
  localparam int    VREF      = 8;
  localparam int    ZSTEP     = 40;
  localparam real   PERIOD    = 5.0;
  localparam int    WDOG_CYC  = 200000;

  typedef struct {
    int cnt;
    bit pol;
    bit ovr;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runHold = 1'b0;
  logic compOut = 1'b0;
  logic selAutoZero, selSignal, selRefForPos, selRefForNeg, selRefCharge, selZeroFb;
  logic [CNT_W-1:0] resCount;
  logic resPolarity, resOverrange, status;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;
  expItem_t expQ[$];

  int  vin = 0;
  bit  stuck = 0;
  int  integ = 0;
  int  sigCnt = 0, posCnt = 0, negCnt = 0, ziCnt = 0, ziBad = 0;
  bit  prevStatus = 0;
  int  cycN = 0;
  int  lastRise = 0;
  bit  haveRise = 0;
  bit  periodArm = 0;
  realtime tPos = 0;

  always #(PERIOD / 2) clk = ~clk;

  adc_seq_top #(.CNT_W(CNT_W)) i_adc_seq_top (
    .clk          (clk),
    .rstN         (rstN),
    .runHold      (runHold),
    .compOut      (compOut),
    .selAutoZero  (selAutoZero),
    .selSignal    (selSignal),
    .selRefForPos (selRefForPos),
    .selRefForNeg (selRefForNeg),
    .selRefCharge (selRefCharge),
    .selZeroFb    (selZeroFb),
    .resCount     (resCount),
    .resPolarity  (resPolarity),
    .resOverrange (resOverrange),
    .status       (status)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  endtask

  // expected result from the integrator behaviour implied by R2..R4
  task automatic predict(input int v, output int cnt, output bit pol, output bit ovr);
    int i0;
    i0  = INTEG_LEN * v;
    pol = (i0 > 0);
    cnt = DEINT_MAX - 1;
    ovr = 1;
    for (int k = 0; k < DEINT_MAX; k++) begin
      int lvl;
      lvl = i0 + (pol ? -VREF : VREF) * (k + 1);
      if ((lvl > 0) != pol) begin
        cnt = k;
        ovr = 0;
        break;
      end
    end
  endtask

  // analog front end model and per-conversion select logger
  always @(negedge clk) begin
    if (status && !prevStatus) begin
      sigCnt = 0; posCnt = 0; negCnt = 0; ziCnt = 0;
    end
    prevStatus = status;
    if (selAutoZero)       integ = 0;
    else if (selSignal)    integ = integ + vin;
    else if (selRefForPos) integ = integ - VREF;
    else if (selRefForNeg) integ = integ + VREF;
    else if (selZeroFb && !stuck) begin
      if (integ > 0)      integ = integ - ZSTEP;
      else if (integ < 0) integ = integ + ZSTEP;
    end
    compOut = (integ > 0);
    if (selSignal)    sigCnt++;
    if (selRefForPos) posCnt++;
    if (selRefForNeg) negCnt++;
    if (selZeroFb) begin
      ziCnt++;
      if (selSignal || !selRefCharge) ziBad++;
    end
  end

  always @(posedge clk) begin
    cycN++;
    tPos = $realtime;
  end

  // start-of-conversion monitor
  always @(posedge status) begin
    if (rstN === 1'b1) begin
      if (haveRise && periodArm)
        check((cycN - lastRise) == CYCLE_LEN, "R9", "conversion spacing",
              cycN - lastRise, CYCLE_LEN);
      lastRise = cycN;
      haveRise = 1;
      #1;
      check(selSignal === 1'b1, "R7", "integrate with status rise", selSignal, 1);
    end
  end

  // scoreboard monitor: result at the data-valid edge
  always @(negedge status) begin
    if (rstN === 1'b1) begin
      check(int'(($realtime - tPos) * 10) == int'(PERIOD * 5), "R8",
            "status fall offset x0.1ns", int'(($realtime - tPos) * 10), int'(PERIOD * 5));
      #1;
      if (expQ.size() == 0) begin
        check(0, "R3", "unexpected result", 0, 1);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(resCount == e.cnt, e.ovr ? "R4" : "R3", "result count", resCount, e.cnt);
        check(resPolarity == e.pol, "R2", "result polarity", resPolarity, e.pol);
        check(resOverrange == e.ovr, "R4", "overrange flag", resOverrange, e.ovr);
      end
    end
  end

  // results may only move while status is high
  always @(resCount or resPolarity or resOverrange) begin
    if (rstN === 1'b1)
      check(status === 1'b1, "R8", "result changed while status low", status, 1);
  end

  task automatic convert(input int v, input bit stk, input int expZi,
                         input bit fromHeld, input bit holdAfter);
    expItem_t it;
    int c;
    bit p, o;
    predict(v, c, p, o);
    it.cnt = c; it.pol = p; it.ovr = o;
    expQ.push_back(it);
    vin = v;
    stuck = stk;
    if (fromHeld) begin
      periodArm = 0;
      @(negedge clk);
      runHold = 1'b1;
      @(posedge clk);
      #1;
      check(status === 1'b1 && selSignal === 1'b1, "R10", "start after release",
            {status, selSignal}, 3);
      periodArm = 1;
    end else if (status !== 1'b1) begin
      @(posedge status);
    end
    if (holdAfter) begin
      #1;
      runHold = 1'b0;
    end
    @(negedge status);
    forever begin
      @(negedge clk);
      #1;
      if (selAutoZero === 1'b1) break;
    end
    check(sigCnt == INTEG_LEN, "R2", "integrate clocks", sigCnt, INTEG_LEN);
    check((p ? posCnt : negCnt) == c + 1, "R3", "deintegrate clocks, matching reference",
          p ? posCnt : negCnt, c + 1);
    check((p ? negCnt : posCnt) == 0, "R3", "deintegrate clocks, wrong reference",
          p ? negCnt : posCnt, 0);
    check(ziCnt == expZi, o ? "R6" : "R5", "recovery clocks", ziCnt, expZi);
  endtask

  initial begin
    #(WDOG_CYC * PERIOD);
    check(0, "R9", "watchdog expired", cycN, WDOG_CYC);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check({status, selAutoZero, selRefCharge, selSignal, selRefForPos, selRefForNeg, selZeroFb} == 7'b0110000,
          "R1", "selects in reset",
          {status, selAutoZero, selRefCharge, selSignal, selRefForPos, selRefForNeg, selZeroFb}, 7'b0110000);
    check({resCount, resPolarity, resOverrange} == '0, "R1", "result in reset",
          {resCount, resPolarity, resOverrange}, 0);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    check(status === 1'b0 && selAutoZero === 1'b1, "R10", "parked after reset",
          {status, selAutoZero}, 1);

    convert(5,   0, 0,      1, 0);
    convert(-5,  0, 0,      0, 0);
    convert(0,   0, 0,      0, 0);
    convert(16,  0, 0,      0, 0);   // flips on the last allowed clock (R4)
    convert(20,  0, 4,      0, 0);   // overrange, early recovery end
    convert(-20, 0, 4,      0, 0);
    convert(20,  1, ZI_MAX, 0, 0);   // recovery hits its limit
    convert(-16, 0, ZI_MAX, 0, 0);
    convert(3,   0, 0,      0, 1);

    begin
      int bad = 0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        #1;
        if (status !== 1'b0 || selAutoZero !== 1'b1) bad++;
      end
      check(bad == 0, "R10", "clocks not parked during hold", bad, 0);
    end

    convert(-7, 0, 0, 1, 0);
    convert(1,  0, 0, 0, 0);

    check(ziBad == 0, "R5", "recovery clocks with wrong switches", ziBad, 0);
    check(expQ.size() == 0, "R3", "results left unseen", expQ.size(), 0);
    repeat (5) @(negedge clk);
    finishRun();
  end

endmodule